// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Core

This block is a small 32-bit processor core that completes one instruction per clock: fetch, decode, operand read, ALU operation, data memory access and register write-back all happen in the same cycle. It has separate instruction and data memory ports. The instruction port presents the program counter and takes the fetched word back combinationally. The data port presents an address, store data and a write strobe, and takes load data back combinationally.

The core runs a fixed set of nine instructions: word load, word store, add, subtract, bitwise and, bitwise or, signed set-less-than, branch-if-equal and an absolute jump. The ALU operation is decoded in two stages. The main decoder turns the opcode into a 2-bit operation class. A second decoder combines that class with the function field of register-format instructions to give a 4-bit ALU code. Any opcode outside the supported set behaves as a no-op.

Top module: `sc_core`

## Requirements
- R1: While rst_ni is low, imem_addr_o is 0 and dmem_we_o is 0, and no register is written. The first instruction after reset release is fetched from address 0.
- R2: When an instruction is neither a taken branch nor a jump, the next fetch address is the current address plus 4.
- R3: Load (opcode 100011) reads data memory at rs + sign-extended imm[15:0] and writes the loaded word into register rt (bits 20:16). rs is taken from bits 25:21.
- R4: Store (opcode 101011) drives dmem_addr_o = rs + sign-extended imm, drives dmem_wdata_o = rt, and asserts dmem_we_o for that single cycle without writing any register.
- R5: Register-format instructions (opcode 000000) write rd (bits 15:11). The function field selects the operation: 100000 is add, 100010 is subtract, 100100 is bitwise and, 100101 is bitwise or.
- R6: Function 101010 writes 1 to rd if rs is less than rt as signed two's-complement values, and writes 0 otherwise.
- R7: The operation class is 00 for load and store, which gives ALU code 0010 (add). It is 01 for branch, which gives 0110 (subtract). It is 10 for register format, where the function field decides: and 0000, or 0001, add 0010, subtract 0110, set-less-than 0111.
- R8: Branch-if-equal (opcode 000100) with rs equal to rt loads PC+4 plus the sign-extended immediate shifted left by 2. With unequal operands the next address is PC+4.
- R9: Jump (opcode 000010) loads {PC[31:28], instr[25:0], 2'b00}.
- R10: Register 0 reads as zero, and any write aimed at it is discarded.
- R11: An unsupported opcode, or a register-format instruction with an unlisted function value, writes no register, does no store, and advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| imem_addr_o | output | 32 | Instruction fetch address (program counter) |
| imem_rdata_i | input | 32 | Fetched instruction word |
| dmem_addr_o | output | 32 | Data memory byte address |
| dmem_wdata_o | output | 32 | Store data |
| dmem_we_o | output | 1 | Store strobe |
| dmem_rdata_i | input | 32 | Load data |

## Verification
Several properties are checked on every clocked cycle by the embedded assertions. They cover sequential PC advance, the taken-branch and jump targets, and the rule that stores never write a register. They also check that load and store always use the add code, that storing register 0 puts out zero, and that set-less-than yields only 0 or 1. The rest can only be shown by the program the bench runs. That includes the actual arithmetic results and the signed compare, load write-back, and not-taken branches. It also includes the skipped instructions after a taken branch or jump, discarded writes to register 0, and the no-op handling of an unknown opcode. The bench makes all of these visible as a predicted sequence of stores and a final steady fetch address.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;

  localparam logic [5:0] OPC_RFMT  = 6'b000000;
  localparam logic [5:0] OPC_LOAD  = 6'b100011;
  localparam logic [5:0] OPC_STORE = 6'b101011;
  localparam logic [5:0] OPC_BEQ   = 6'b000100;
  localparam logic [5:0] OPC_JUMP  = 6'b000010;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

  typedef enum logic [1:0] {
    OPCLS_ADD   = 2'b00,
    OPCLS_SUB   = 2'b01,
    OPCLS_FUNCT = 2'b10
  } op_class_e;

  typedef enum logic [3:0] {
    ALU_AND = 4'b0000,
    ALU_OR  = 4'b0001,
    ALU_ADD = 4'b0010,
    ALU_SUB = 4'b0110,
    ALU_SLT = 4'b0111
  } alu_code_e;

  typedef struct packed {
    logic      reg_we;
    logic      dst_rd;
    logic      src_imm;
    logic      mem_we;
    logic      mem_to_reg;
    logic      branch;
    logic      jump;
    op_class_e op_class;
  } ctrl_t;

endpackage

// File: rtl/sc_core_ctrl.sv
module sc_core_ctrl
  import sc_core_pkg::*;
(
  input  logic [5:0] opcode_i,
  output ctrl_t      ctrl_o
);
  always_comb begin
    ctrl_o = '{reg_we: 1'b0, dst_rd: 1'b0, src_imm: 1'b0, mem_we: 1'b0,
               mem_to_reg: 1'b0, branch: 1'b0, jump: 1'b0, op_class: OPCLS_ADD};
    case (opcode_i)
      OPC_RFMT: begin
        ctrl_o.reg_we   = 1'b1;
        ctrl_o.dst_rd   = 1'b1;
        ctrl_o.op_class = OPCLS_FUNCT;
      end
      OPC_LOAD: begin
        ctrl_o.reg_we     = 1'b1;
        ctrl_o.src_imm    = 1'b1;
        ctrl_o.mem_to_reg = 1'b1;
      end
      OPC_STORE: begin
        ctrl_o.src_imm = 1'b1;
        ctrl_o.mem_we  = 1'b1;
      end
      OPC_BEQ: begin
        ctrl_o.branch   = 1'b1;
        ctrl_o.op_class = OPCLS_SUB;
      end
      OPC_JUMP: ctrl_o.jump = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/sc_core_alu_dec.sv
module sc_core_alu_dec
  import sc_core_pkg::*;
(
  input  op_class_e op_class_i,
  input  logic [5:0] funct_i,
  output alu_code_e  alu_code_o,
  output logic       funct_ok_o
);
  always_comb begin
    alu_code_o = ALU_ADD;
    funct_ok_o = 1'b1;
    case (op_class_i)
      OPCLS_ADD: alu_code_o = ALU_ADD;
      OPCLS_SUB: alu_code_o = ALU_SUB;
      OPCLS_FUNCT: begin
        case (funct_i)
          FN_ADD:  alu_code_o = ALU_ADD;
          FN_SUB:  alu_code_o = ALU_SUB;
          FN_AND:  alu_code_o = ALU_AND;
          FN_OR:   alu_code_o = ALU_OR;
          FN_SLT:  alu_code_o = ALU_SLT;
          default: funct_ok_o = 1'b0;
        endcase
      end
      default: alu_code_o = ALU_ADD;
    endcase
  end
endmodule

// File: rtl/sc_core_alu.sv
module sc_core_alu
  import sc_core_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  alu_code_e       code_i,
  output logic [XLEN-1:0] result_o,
  output logic            zero_o
);
  logic lt_signed;
  assign lt_signed = $signed(a_i) < $signed(b_i);

  always_comb begin
    case (code_i)
      ALU_AND: result_o = a_i & b_i;
      ALU_OR:  result_o = a_i | b_i;
      ALU_ADD: result_o = a_i + b_i;
      ALU_SUB: result_o = a_i - b_i;
      ALU_SLT: result_o = {{(XLEN-1){1'b0}}, lt_signed};
      default: result_o = '0;
    endcase
  end

  assign zero_o = (result_o == '0);

  // R6: set-less-than yields a pure boolean
  always_comb begin
    if (code_i == ALU_SLT) begin
      a_r6_slt_bool: assert (result_o[XLEN-1:1] == '0);
    end
  end
endmodule

// File: rtl/sc_core_regfile.sv
module sc_core_regfile #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned NREGS = 32,
  localparam int unsigned AW   = $clog2(NREGS)
) (
  input  logic            clk_i,
  input  logic [AW-1:0]   raddr_a_i,
  input  logic [AW-1:0]   raddr_b_i,
  output logic [XLEN-1:0] rdata_a_o,
  output logic [XLEN-1:0] rdata_b_o,
  input  logic            we_i,
  input  logic [AW-1:0]   waddr_i,
  input  logic [XLEN-1:0] wdata_i
);
  logic [XLEN-1:0] regs [NREGS];

  always_ff @(posedge clk_i) begin
    if (we_i && (waddr_i != '0)) regs[waddr_i] <= wdata_i;
  end

  assign rdata_a_o = (raddr_a_i == '0) ? '0 : regs[raddr_a_i];
  assign rdata_b_o = (raddr_b_i == '0) ? '0 : regs[raddr_b_i];
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_core_pkg::*;
#(
  parameter int unsigned XLEN     = 32,
  parameter int unsigned NREGS    = 32,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  output logic [31:0] imem_addr_o,
  input  logic [31:0] imem_rdata_i,
  output logic [31:0] dmem_addr_o,
  output logic [31:0] dmem_wdata_o,
  output logic        dmem_we_o,
  input  logic [31:0] dmem_rdata_i
);
  localparam int unsigned AW = $clog2(NREGS);

  logic [XLEN-1:0] pc_q, pc_next, pc_plus4, br_target, jmp_target;
  logic [XLEN-1:0] imm_ext, rs_val, rt_val, alu_b, alu_res, wb_data;
  logic [31:0]     instr;
  logic [5:0]      opcode, funct;
  logic [AW-1:0]   rs_idx, rt_idx, rd_idx, waddr;
  ctrl_t           ctrl;
  alu_code_e       alu_code;
  logic            funct_ok, alu_zero, br_taken, rf_we;

  assign instr  = imem_rdata_i;
  assign opcode = instr[31:26];
  assign funct  = instr[5:0];
  assign rs_idx = instr[25:21];
  assign rt_idx = instr[20:16];
  assign rd_idx = instr[15:11];

  sc_core_ctrl u_ctrl (
    .opcode_i (opcode),
    .ctrl_o   (ctrl)
  );

  sc_core_alu_dec u_alu_dec (
    .op_class_i (ctrl.op_class),
    .funct_i    (funct),
    .alu_code_o (alu_code),
    .funct_ok_o (funct_ok)
  );

  assign waddr = ctrl.dst_rd ? rd_idx : rt_idx;
  assign rf_we = ctrl.reg_we & funct_ok & rst_ni;

  sc_core_regfile #(.XLEN(XLEN), .NREGS(NREGS)) u_rf (
    .clk_i     (clk_i),
    .raddr_a_i (rs_idx),
    .raddr_b_i (rt_idx),
    .rdata_a_o (rs_val),
    .rdata_b_o (rt_val),
    .we_i      (rf_we),
    .waddr_i   (waddr),
    .wdata_i   (wb_data)
  );

  assign imm_ext = {{(XLEN-16){instr[15]}}, instr[15:0]};
  assign alu_b   = ctrl.src_imm ? imm_ext : rt_val;

  sc_core_alu #(.XLEN(XLEN)) u_alu (
    .a_i      (rs_val),
    .b_i      (alu_b),
    .code_i   (alu_code),
    .result_o (alu_res),
    .zero_o   (alu_zero)
  );

  assign wb_data = ctrl.mem_to_reg ? dmem_rdata_i : alu_res;

  // next-PC selection
  assign pc_plus4   = pc_q + XLEN'(4);
  assign br_target  = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};
  assign jmp_target = {pc_q[XLEN-1:XLEN-4], instr[25:0], 2'b00};
  assign br_taken   = ctrl.branch & alu_zero;

  always_comb begin
    if (ctrl.jump)     pc_next = jmp_target;
    else if (br_taken) pc_next = br_target;
    else               pc_next = pc_plus4;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= RESET_PC;
    else         pc_q <= pc_next;
  end

  assign imem_addr_o  = pc_q;
  assign dmem_addr_o  = alu_res;
  assign dmem_wdata_o = rt_val;
  assign dmem_we_o    = ctrl.mem_we & rst_ni;

  a_r2_seq_pc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl.jump && !(ctrl.branch && rs_val == rt_val)) |=> (pc_q == $past(pc_q) + XLEN'(4)));

  a_r8_beq_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opcode == OPC_BEQ && rs_val == rt_val) |=>
      (pc_q == $past(pc_q) + XLEN'(4) + ($past(imm_ext) << 2)));

  a_r9_jump: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opcode == OPC_JUMP) |=>
      (pc_q[XLEN-5:0] == {$past(imem_rdata_i[25:0]), 2'b00}
       && pc_q[XLEN-1:XLEN-4] == $past(pc_q[XLEN-1:XLEN-4])));

  a_r7_mem_add: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opcode == OPC_LOAD || opcode == OPC_STORE) |-> (alu_code == ALU_ADD));

  a_r4_store_no_regwrite: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dmem_we_o |-> !rf_we);

  a_r10_zero_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dmem_we_o && rt_idx == '0) |-> (dmem_wdata_o == '0));
endmodule

// File: tb/sc_core_bench.sv
module sc_core_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] imem_addr_o, imem_rdata_i;
  logic [31:0] dmem_addr_o, dmem_wdata_o, dmem_rdata_i;
  logic        dmem_we_o;

  logic [31:0] imem [64];
  logic [31:0] dmem [64];

  int errors = 0;
  int checks = 0;

  logic [31:0] q_addr [$];
  logic [31:0] q_data [$];
  string       q_req  [$];

  always #4 clk_i = ~clk_i;

  sc_core u_sc_core (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .imem_addr_o  (imem_addr_o),
    .imem_rdata_i (imem_rdata_i),
    .dmem_addr_o  (dmem_addr_o),
    .dmem_wdata_o (dmem_wdata_o),
    .dmem_we_o    (dmem_we_o),
    .dmem_rdata_i (dmem_rdata_i)
  );

  assign imem_rdata_i = imem[imem_addr_o[7:2]];
  assign dmem_rdata_i = dmem[dmem_addr_o[7:2]];

  always @(posedge clk_i) begin
    if (dmem_we_o) dmem[dmem_addr_o[7:2]] <= dmem_wdata_o;
  end

  function automatic logic [31:0] enc_r(logic [4:0] rs, logic [4:0] rt, logic [4:0] rd, logic [5:0] fn);
    return {6'b000000, rs, rt, rd, 5'b00000, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rs, logic [4:0] rt, logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_store(logic [31:0] a, logic [31:0] d, string req);
    q_addr.push_back(a);
    q_data.push_back(d);
    q_req.push_back(req);
  endtask

  // monitor: every store the core issues is matched against the queue
  always @(negedge clk_i) begin
    if (rst_ni && dmem_we_o) begin
      if (q_addr.size() == 0) begin
        check("R8/R9 unexpected store addr", dmem_addr_o, 32'hFFFF_FFFF);
      end else begin
        string r;
        r = q_req.pop_front();
        check({r, " addr"}, dmem_addr_o, q_addr.pop_front());
        check({r, " data"}, dmem_wdata_o, q_data.pop_front());
      end
    end
  end

  initial begin
    #(8 * 5000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      imem[i] = 32'h0;
      dmem[i] = 32'h0;
    end
    dmem[0] = 32'd5;
    dmem[1] = 32'hFFFF_FFFD;

    imem[0]  = enc_i(6'b100011, 0, 1, 16'd0);      // lw r1,0
    imem[1]  = enc_i(6'b100011, 0, 2, 16'd4);      // lw r2,4
    imem[2]  = enc_r(1, 2, 3, 6'b100000);          // add
    imem[3]  = enc_r(1, 2, 4, 6'b100010);          // sub
    imem[4]  = enc_r(1, 2, 5, 6'b100100);          // and
    imem[5]  = enc_r(1, 2, 6, 6'b100101);          // or
    imem[6]  = enc_r(2, 1, 7, 6'b101010);          // slt -3<5
    imem[7]  = enc_r(1, 2, 8, 6'b101010);          // slt 5<-3
    imem[8]  = enc_r(1, 1, 0, 6'b100000);          // write to r0
    imem[9]  = enc_i(6'b101011, 0, 3, 16'd16);
    imem[10] = enc_i(6'b101011, 0, 4, 16'd20);
    imem[11] = enc_i(6'b101011, 0, 5, 16'd24);
    imem[12] = enc_i(6'b101011, 0, 6, 16'd28);
    imem[13] = enc_i(6'b101011, 0, 7, 16'd32);
    imem[14] = enc_i(6'b101011, 0, 8, 16'd36);
    imem[15] = enc_i(6'b101011, 0, 0, 16'd40);
    imem[16] = enc_i(6'b000100, 1, 2, 16'd5);      // beq not taken
    imem[17] = enc_i(6'b101011, 0, 1, 16'd44);
    imem[18] = enc_i(6'b000100, 1, 1, 16'd2);      // beq taken -> 84
    imem[19] = enc_i(6'b101011, 0, 2, 16'd48);
    imem[20] = enc_i(6'b101011, 0, 2, 16'd52);
    imem[21] = enc_i(6'b101011, 0, 2, 16'd56);
    imem[22] = {6'b000010, 26'd25};                // j 100
    imem[23] = enc_i(6'b101011, 0, 1, 16'd60);
    imem[24] = enc_i(6'b101011, 0, 1, 16'd64);
    imem[25] = enc_i(6'b001000, 0, 1, 16'd9);      // unsupported opcode
    imem[26] = enc_i(6'b100011, 0, 9, 16'd16);     // lw r9,16
    imem[27] = enc_i(6'b101011, 0, 9, 16'd68);
    imem[28] = enc_i(6'b101011, 0, 1, 16'd72);
    imem[29] = enc_i(6'b000100, 0, 0, 16'hFFFF);   // loop on itself

    expect_store(32'd16, 32'd2,          "R5 add");
    expect_store(32'd20, 32'd8,          "R5 sub");
    expect_store(32'd24, 32'd5,          "R5 and");
    expect_store(32'd28, 32'hFFFF_FFFD,  "R5 or");
    expect_store(32'd32, 32'd1,          "R6 slt true");
    expect_store(32'd36, 32'd0,          "R6 slt false");
    expect_store(32'd40, 32'd0,          "R10 r0 zero");
    expect_store(32'd44, 32'd5,          "R8 not taken");
    expect_store(32'd56, 32'hFFFF_FFFD,  "R8 taken target");
    expect_store(32'd68, 32'd2,          "R3 load writeback");
    expect_store(32'd72, 32'd5,          "R11 unknown opcode");

    repeat (3) @(negedge clk_i);
    check("R1 reset pc", imem_addr_o, 32'd0);
    check("R1 reset no store", {31'd0, dmem_we_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R2 pc after first", imem_addr_o, 32'd4);
    @(negedge clk_i);
    check("R2 pc sequential", imem_addr_o, 32'd8);

    repeat (40) @(negedge clk_i);
    check("R8 backward loop pc", imem_addr_o, 32'd116);
    @(negedge clk_i);
    check("R8 loop holds pc", imem_addr_o, 32'd116);
    check("R4 all stores seen", q_addr.size(), 32'd0);
    check("R8 skipped store 48", dmem[12], 32'd0);
    check("R8 skipped store 52", dmem[13], 32'd0);
    check("R9 skipped store 60", dmem[15], 32'd0);
    check("R9 skipped store 64", dmem[16], 32'd0);
    check("R4 stored word kept", dmem[4], 32'd2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule